// File: doc/BRIEF.md
# Grid Snake Body Tracker

This block holds the cell coordinates of every segment of a snake that crawls over a rectangular cell grid. A single-cycle movement tick, supplied by a slow timebase elsewhere in the chip, makes the snake take one step. On that step the head moves one cell in the current heading. Every body segment moves into the cell that the segment in front of it held before the step. Four direction buttons choose the heading. The heading is latched on the clock edge where a button is seen, and the snake keeps that heading on every later tick until another button is accepted.

An apple cell is given from outside. When the step would put the head on the apple, the block raises a one-cycle eaten pulse and makes the snake one segment longer. The new segment appears at the tail, because the shift has already copied the old tail cell one slot further back. A step that would enter the wall ring or a cell of the live body is not taken. Instead the block raises a game-over flag, which stays set until reset. Drawing, apple placement and scoring belong to other blocks.

Top module: `snake_tracker`

## Requirements
- R1: After reset the head is at cell (10,15), the other two live segments are at (9,15) and (8,15), the length is 3, the heading is rightward, and both game-over and the eaten pulse are low.
- R2: On each accepted tick the head moves one cell in the heading: right adds 1 to x, left subtracts 1 from x, up subtracts 1 from y, down adds 1 to y. The heading persists from tick to tick.
- R3: While the tick input is low, no coordinate, length or flag changes, except for the heading latch.
- R4: On each accepted tick, segment i (for i of 1 or more) takes the cell that segment i-1 held before the tick, for all MAX_LEN slots.
- R5: A button is latched on the clock edge where it is high and is used from the next tick on. When several buttons are high together, up wins over down, down over left, and left over right.
- R6: A request for the exact opposite of the heading used on the last step is ignored while the length is above 1.
- R7: When the cell the head is about to enter equals the apple cell, the eaten output is high for the one cycle after that tick edge, and the length rises by 1.
- R8: The length never exceeds MAX_LEN (default 32). Eating at that length still pulses the eaten output but leaves the length unchanged.
- R9: A step into a wall cell (x of 0 or 39, y of 0 or 29) sets game-over on that tick edge and leaves every segment where it was. Game-over stays set until reset.
- R10: A step is a self-hit only if the target cell equals one of segments 1 to length-1. Slots beyond the length, which are parked at (11,15) by reset, are never compared.
- R11: Once game-over is set, later ticks move nothing and eat nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| moveTick | input | 1 | One-cycle step request |
| btnUp | input | 1 | Request upward heading |
| btnDown | input | 1 | Request downward heading |
| btnLeft | input | 1 | Request leftward heading |
| btnRight | input | 1 | Request rightward heading |
| appleX | input | 6 | Apple cell column |
| appleY | input | 6 | Apple cell row |
| headX | output | 6 | Head column |
| headY | output | 6 | Head row |
| segX | output | 192 | Columns of all slots, slot i at bits [6i+5:6i] |
| segY | output | 192 | Rows of all slots, slot i at bits [6i+5:6i] |
| snakeLen | output | 6 | Number of live segments |
| appleEaten | output | 1 | One-cycle pulse after an apple is taken |
| gameOver | output | 1 | Sticky end-of-play flag |

## Verification
Every result of a step is registered once. The head, the segment slots, the length, the eaten pulse and game-over all take their new values on the same edge where moveTick is sampled high, so they can be read on the falling edge that follows. A button press changes nothing that can be seen until the next tick, which then shows the new heading in the head position. The bench drives its inputs on falling edges. Its behavioural model steps on the same rising edges as the design. Every output is compared on each falling edge, so each result is checked in exactly the cycle it is due. Named checks at the corner cases make sure each requirement is reported on its own.

// File: rtl/snake_pkg.sv
package snake_pkg;

  typedef enum logic [1:0] {
    DIR_RIGHT = 2'd0,
    DIR_UP    = 2'd1,
    DIR_LEFT  = 2'd2,
    DIR_DOWN  = 2'd3
  } dir_t;

  // strobes from control to the segment datapath
  typedef struct packed {
    logic shift;  // take one step
    logic grow;   // lengthen by one on this step
    logic halt;   // collision: freeze play
  } strobes_t;

  function automatic dir_t reverseOf(dir_t d);
    case (d)
      DIR_RIGHT: return DIR_LEFT;
      DIR_LEFT:  return DIR_RIGHT;
      DIR_UP:    return DIR_DOWN;
      default:   return DIR_UP;
    endcase
  endfunction

endpackage

// File: rtl/snake_ctrl.sv
module snake_ctrl
  import snake_pkg::*;
#(
  parameter int MAX_LEN = 32,
  localparam int LEN_W = $clog2(MAX_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             moveTick,
  input  logic             btnUp,
  input  logic             btnDown,
  input  logic             btnLeft,
  input  logic             btnRight,
  input  logic [LEN_W-1:0] snakeLen,
  input  logic             wallHit,
  input  logic             selfHit,
  input  logic             appleHit,
  output dir_t             heading,
  output strobes_t         strb,
  output logic             gameOver,
  output logic             appleEaten
);

  dir_t movedDir;
  dir_t reqDir;
  logic reqValid;
  logic liveTick;
  logic anyHit;
  logic reqBlocked;

  // button priority: up, down, left, right
  always_comb begin
    reqValid = 1'b1;
    reqDir   = DIR_RIGHT;
    if (btnUp)         reqDir = DIR_UP;
    else if (btnDown)  reqDir = DIR_DOWN;
    else if (btnLeft)  reqDir = DIR_LEFT;
    else if (btnRight) reqDir = DIR_RIGHT;
    else               reqValid = 1'b0;
  end

  assign reqBlocked = (snakeLen > LEN_W'(1)) && (reqDir == reverseOf(movedDir));

  always_comb begin
    liveTick    = moveTick && !gameOver;
    anyHit      = wallHit || selfHit;
    strb.shift  = liveTick && !anyHit;
    strb.halt   = liveTick && anyHit;
    strb.grow   = liveTick && !anyHit && appleHit && (snakeLen < LEN_W'(MAX_LEN));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      heading    <= DIR_RIGHT;
      movedDir   <= DIR_RIGHT;
      gameOver   <= 1'b0;
      appleEaten <= 1'b0;
    end else begin
      appleEaten <= strb.shift && appleHit;
      if (strb.halt)  gameOver <= 1'b1;
      if (strb.shift) movedDir <= heading;
      if (reqValid && !reqBlocked) heading <= reqDir;
    end
  end

  // R9
  over_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gameOver |=> gameOver);

  // R9
  over_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gameOver) |-> $past(moveTick));

  // R7
  eaten_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    appleEaten |-> $past(moveTick) && !$past(gameOver));

endmodule

// File: rtl/snake_body.sv
module snake_body
  import snake_pkg::*;
#(
  parameter int COORD_W  = 6,
  parameter int GRID_W   = 40,
  parameter int GRID_H   = 30,
  parameter int MAX_LEN  = 32,
  parameter int INIT_LEN = 3,
  parameter int START_X  = 10,
  parameter int START_Y  = 15,
  localparam int LEN_W   = $clog2(MAX_LEN + 1),
  localparam int FLAT_W  = MAX_LEN * COORD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  dir_t               heading,
  input  strobes_t           strb,
  input  logic [COORD_W-1:0] appleX,
  input  logic [COORD_W-1:0] appleY,
  output logic [COORD_W-1:0] headX,
  output logic [COORD_W-1:0] headY,
  output logic [FLAT_W-1:0]  segX,
  output logic [FLAT_W-1:0]  segY,
  output logic [LEN_W-1:0]   snakeLen,
  output logic               wallHit,
  output logic               selfHit,
  output logic               appleHit
);

  logic [COORD_W-1:0] xs [MAX_LEN];
  logic [COORD_W-1:0] ys [MAX_LEN];
  logic [COORD_W-1:0] nextX;
  logic [COORD_W-1:0] nextY;

  always_comb begin
    nextX = xs[0];
    nextY = ys[0];
    case (heading)
      DIR_RIGHT: nextX = xs[0] + COORD_W'(1);
      DIR_LEFT:  nextX = xs[0] - COORD_W'(1);
      DIR_UP:    nextY = ys[0] - COORD_W'(1);
      default:   nextY = ys[0] + COORD_W'(1);
    endcase
  end

  assign wallHit = (nextX == '0) || (nextX == COORD_W'(GRID_W - 1)) ||
                   (nextY == '0) || (nextY == COORD_W'(GRID_H - 1));

  assign appleHit = (nextX == appleX) && (nextY == appleY);

  // only live segments 1..len-1 take part
  always_comb begin
    selfHit = 1'b0;
    for (int i = 1; i < MAX_LEN; i++) begin
      if ((LEN_W'(i) < snakeLen) && (xs[i] == nextX) && (ys[i] == nextY))
        selfHit = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MAX_LEN; i++) begin
        xs[i] <= (i < INIT_LEN) ? COORD_W'(START_X - i) : COORD_W'(START_X + 1);
        ys[i] <= COORD_W'(START_Y);
      end
      snakeLen <= LEN_W'(INIT_LEN);
    end else if (strb.shift) begin
      xs[0] <= nextX;
      ys[0] <= nextY;
      for (int i = 1; i < MAX_LEN; i++) begin
        xs[i] <= xs[i-1];
        ys[i] <= ys[i-1];
      end
      if (strb.grow) snakeLen <= snakeLen + LEN_W'(1);
    end
  end

  assign headX = xs[0];
  assign headY = ys[0];

  for (genvar g = 0; g < MAX_LEN; g++) begin : g_flat
    assign segX[g*COORD_W +: COORD_W] = xs[g];
    assign segY[g*COORD_W +: COORD_W] = ys[g];
  end

  // R8
  len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snakeLen <= LEN_W'(MAX_LEN)) && (snakeLen != '0));

  // R7
  len_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snakeLen != $past(snakeLen)) |-> ((snakeLen - $past(snakeLen)) == LEN_W'(1)));

  // R3
  head_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(strb.shift) |-> ($stable(headX) && $stable(headY)));

endmodule

// File: rtl/snake_tracker.sv
module snake_tracker
  import snake_pkg::*;
#(
  parameter int COORD_W  = 6,
  parameter int GRID_W   = 40,
  parameter int GRID_H   = 30,
  parameter int MAX_LEN  = 32,
  parameter int INIT_LEN = 3,
  parameter int START_X  = 10,
  parameter int START_Y  = 15
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          moveTick,
  input  logic                          btnUp,
  input  logic                          btnDown,
  input  logic                          btnLeft,
  input  logic                          btnRight,
  input  logic [COORD_W-1:0]            appleX,
  input  logic [COORD_W-1:0]            appleY,
  output logic [COORD_W-1:0]            headX,
  output logic [COORD_W-1:0]            headY,
  output logic [MAX_LEN*COORD_W-1:0]    segX,
  output logic [MAX_LEN*COORD_W-1:0]    segY,
  output logic [$clog2(MAX_LEN+1)-1:0]  snakeLen,
  output logic                          appleEaten,
  output logic                          gameOver
);

  dir_t     heading;
  strobes_t strb;
  logic     wallHit;
  logic     selfHit;
  logic     appleHit;

  snake_ctrl #(.MAX_LEN(MAX_LEN)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .moveTick(moveTick),
    .btnUp(btnUp), .btnDown(btnDown), .btnLeft(btnLeft), .btnRight(btnRight),
    .snakeLen(snakeLen), .wallHit(wallHit), .selfHit(selfHit), .appleHit(appleHit),
    .heading(heading), .strb(strb), .gameOver(gameOver), .appleEaten(appleEaten)
  );

  snake_body #(
    .COORD_W(COORD_W), .GRID_W(GRID_W), .GRID_H(GRID_H), .MAX_LEN(MAX_LEN),
    .INIT_LEN(INIT_LEN), .START_X(START_X), .START_Y(START_Y)
  ) i_body (
    .clk(clk), .rst_n(rst_n), .heading(heading), .strb(strb),
    .appleX(appleX), .appleY(appleY),
    .headX(headX), .headY(headY), .segX(segX), .segY(segY),
    .snakeLen(snakeLen), .wallHit(wallHit), .selfHit(selfHit), .appleHit(appleHit)
  );

endmodule

// File: tb/test_snake_tracker.sv
module test_snake_tracker;

  localparam int CW = 6;
  localparam int ML = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic moveTick = 1'b0;
  logic btnUp = 1'b0, btnDown = 1'b0, btnLeft = 1'b0, btnRight = 1'b0;
  logic [CW-1:0] appleX = '0, appleY = '0;
  logic [CW-1:0] headX, headY;
  logic [ML*CW-1:0] segX, segY;
  logic [5:0] snakeLen;
  logic appleEaten, gameOver;

  always #5 clk = ~clk;

  snake_tracker i_snake_tracker (
    .clk(clk), .rst_n(rst_n), .moveTick(moveTick),
    .btnUp(btnUp), .btnDown(btnDown), .btnLeft(btnLeft), .btnRight(btnRight),
    .appleX(appleX), .appleY(appleY),
    .headX(headX), .headY(headY), .segX(segX), .segY(segY),
    .snakeLen(snakeLen), .appleEaten(appleEaten), .gameOver(gameOver)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // behavioural model: 0 right, 1 up, 2 left, 3 down
  int mx[$];
  int my[$];
  int mDir, mMoved, mLen;
  bit mOver, mEaten;
  int dxs[4] = '{1, 0, -1, 0};
  int dys[4] = '{0, -1, 0, 1};

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      mx.delete(); my.delete();
      for (int i = 0; i < ML; i++) begin
        mx.push_back(i < 3 ? 10 - i : 11);
        my.push_back(15);
      end
      mDir = 0; mMoved = 0; mLen = 3; mOver = 0; mEaten = 0;
    end else begin
      int oldDir, oldMoved, oldLen, req;
      oldDir = mDir; oldMoved = mMoved; oldLen = mLen;
      mEaten = 0;
      if (moveTick && !mOver) begin
        int nx, ny;
        bit hit;
        nx = mx[0] + dxs[oldDir];
        ny = my[0] + dys[oldDir];
        hit = (nx == 0) || (nx == 39) || (ny == 0) || (ny == 29);
        for (int i = 1; i < oldLen; i++)
          if (mx[i] == nx && my[i] == ny) hit = 1;
        if (hit) mOver = 1;
        else begin
          mx.push_front(nx); my.push_front(ny);
          void'(mx.pop_back()); void'(my.pop_back());
          mMoved = oldDir;
          if (nx == int'(appleX) && ny == int'(appleY)) begin
            mEaten = 1;
            if (mLen < ML) mLen++;
          end
        end
      end
      req = btnUp ? 1 : btnDown ? 3 : btnLeft ? 2 : btnRight ? 0 : -1;
      if (req >= 0 && !(oldLen > 1 && req == ((oldMoved + 2) % 4))) mDir = req;
    end
  end

  // compare every output on every falling edge out of reset
  always @(negedge clk) begin
    if (rst_n) begin
      int badSlot;
      badSlot = -1;
      chk(int'(headX) == mx[0] && int'(headY) == my[0], "R2", "head x*64+y",
          int'(headX) * 64 + int'(headY), mx[0] * 64 + my[0]);
      for (int i = ML - 1; i >= 0; i--)
        if (int'(segX[i*CW +: CW]) != mx[i] || int'(segY[i*CW +: CW]) != my[i]) badSlot = i;
      chk(badSlot < 0, "R4", "first mismatching slot", badSlot, -1);
      chk(int'(snakeLen) == mLen, "R7", "length", int'(snakeLen), mLen);
      chk(appleEaten == mEaten, "R7", "eaten pulse", int'(appleEaten), int'(mEaten));
      chk(gameOver == mOver, "R9", "game over", int'(gameOver), int'(mOver));
    end
  end

  task automatic doTick();
    @(negedge clk) moveTick = 1'b1;
    @(negedge clk) moveTick = 1'b0;
    @(negedge clk);
  endtask

  task automatic press(int d);
    @(negedge clk);
    btnUp = (d == 1); btnLeft = (d == 2); btnDown = (d == 3); btnRight = (d == 0);
    @(negedge clk);
    btnUp = 0; btnLeft = 0; btnDown = 0; btnRight = 0;
  endtask

  task automatic doReset();
    @(negedge clk) rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      chk(0, "R2", "watchdog expired", cycles, 100000);
      finishRun();
    end
  end

  initial begin
    // phase A: reset, idle, reverse, priority, wall
    doReset();
    chk(headX == 6'd10 && headY == 6'd15, "R1", "reset head x", int'(headX), 10);
    chk(segX[CW +: CW] == 6'd9 && segX[2*CW +: CW] == 6'd8, "R1", "reset slot1 x", int'(segX[CW +: CW]), 9);
    chk(snakeLen == 6'd3 && !gameOver && !appleEaten, "R1", "reset length", int'(snakeLen), 3);
    repeat (5) @(negedge clk);
    chk(headX == 6'd10 && headY == 6'd15, "R3", "head without tick", int'(headX), 10);
    doTick();
    chk(headX == 6'd11 && !gameOver, "R10", "parked slot not compared, head x", int'(headX), 11);
    press(2);
    doTick();
    chk(headX == 6'd12 && headY == 6'd15, "R6", "reverse ignored, head x", int'(headX), 12);
    @(negedge clk);
    btnUp = 1; btnRight = 1;
    @(negedge clk);
    btnUp = 0; btnRight = 0;
    chk(headY == 6'd15, "R5", "no move before tick, head y", int'(headY), 15);
    doTick();
    chk(headX == 6'd12 && headY == 6'd14, "R5", "up wins, head y", int'(headY), 14);
    repeat (13) doTick();
    chk(headY == 6'd1 && !gameOver, "R2", "heading kept, head y", int'(headY), 1);
    doTick();
    chk(gameOver && headY == 6'd1, "R9", "wall stop, head y", int'(headY), 1);
    repeat (3) doTick();
    chk(gameOver && headY == 6'd1 && headX == 6'd12, "R11", "frozen head y", int'(headY), 1);

    // phase B: eat along a loop up to the cap, then hit own body
    doReset();
    for (int k = 0; k < 40; k++) begin
      if (mDir == 0 && mx[0] == 30) press(1);
      else if (mDir == 1 && my[0] == 5) press(2);
      else if (mDir == 2 && mx[0] == 5) press(3);
      else if (mDir == 3 && my[0] == 25) press(0);
      @(negedge clk);
      appleX = CW'(mx[0] + dxs[mDir]);
      appleY = CW'(my[0] + dys[mDir]);
      doTick();
    end
    chk(snakeLen == 6'd32, "R8", "capped length", int'(snakeLen), 32);
    appleX = '0; appleY = '0;
    press(3); doTick();
    press(0); doTick();
    press(1); doTick();
    chk(gameOver, "R10", "self hit", int'(gameOver), 1);
    chk(headX == 6'd21 && headY == 6'd6, "R10", "head held at x", int'(headX), 21);
    finishRun();
  end

endmodule